// File: doc/BRIEF.md
# Load/Store Alignment and Extension Unit

This unit sits on the data side of a 32-bit load/store core. For every memory request it adds the base register to the sign-extended 12-bit offset, checks that the result suits the access width, and drives a word-aligned address with per-byte write strobes to a 32-bit little-endian memory. Store data is copied into every lane it could occupy, so the strobes alone choose which bytes are written.

Loads return one cycle later. The unit remembers the lane, the width, the extension kind and the destination register of each load it issued. It then cuts the addressed byte, halfword or word out of the returned word and extends it with sign or zero. A misaligned or unknown access is flagged at once and never reaches memory. A load aimed at register zero still goes to memory and still reports faults; only the write-back enable stays low.

Top module: `ldst_format_unit`

## Requirements
- R1: The effective address `eff_addr` equals `rs1` plus `imm12` sign-extended to 32 bits, with wrap-around modulo 2^32. `mem_addr` is that address with bits [1:0] forced to zero.
- R2: Width codes are `funct3[1:0]`: 00 byte, 01 halfword, 10 word. A valid, legal halfword access with address bit 0 set, or word access with address bits [1:0] nonzero, raises `misaligned` and keeps `mem_req` low. Byte accesses never raise it.
- R3: `byte_en` is 0001 shifted left by address bits [1:0] for bytes, 0011 shifted left by 2×bit 1 for halfwords, and 1111 for words.
- R4: For stores, `mem_wdata` is `rs2[7:0]` repeated four times for byte, `rs2[15:0]` repeated twice for halfword, and `rs2` for word.
- R5: A byte load (funct3 000 signed, 100 unsigned) returns `mem_rdata` byte lane addr[1:0], sign- or zero-extended to 32 bits.
- R6: A halfword load (funct3 001 signed, 101 unsigned) returns bits [15:0] when addr[1]=0 and bits [31:16] when addr[1]=1, extended as its code says.
- R7: A word load (funct3 010) returns `mem_rdata` unchanged.
- R8: Legal codes are 000, 001, 010, 100, 101 for loads and 000, 001, 010 for stores. Any other valid request raises `illegal`, keeps `mem_req` low and leaves `misaligned` low.
- R9: A load with `rd` = 0 still issues `mem_req` and still reports `misaligned`. Its response asserts `load_valid` with `load_wb_en` low.
- R10: `load_valid` is high in exactly the cycle after a cycle in which a load was issued (`mem_req` high, `mem_we` low). It carries that load's `rd` on `load_rd`. Stores and rejected requests produce no response.
- R11: While reset is held, and for the reset-synchronizer cycles after its release, `mem_req` and `load_valid` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_is_store | input | 1 | 1 = store, 0 = load |
| funct3 | input | 3 | Width and extension code |
| rs1 | input | 32 | Base register value |
| imm12 | input | 12 | Signed address offset |
| rs2 | input | 32 | Store source value |
| rd | input | 5 | Load destination index |
| mem_rdata | input | 32 | Read word, valid the cycle after a load is issued |
| mem_req | output | 1 | Access sent to memory |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word-aligned address |
| byte_en | output | 4 | Byte lane strobes |
| mem_wdata | output | 32 | Lane-replicated store data |
| eff_addr | output | 32 | Full effective address (fault address) |
| misaligned | output | 1 | Address-misaligned exception |
| illegal | output | 1 | Unknown width code |
| load_valid | output | 1 | Load result present |
| load_data | output | 32 | Extended load result |
| load_rd | output | 5 | Destination of the result |
| load_wb_en | output | 1 | Result should be written back |

## Verification
The request side is purely combinational. A wrong decode or alignment check shows in the same cycle on `byte_en`, `mem_req`, `misaligned` or `illegal`. The only state is the captured lane, width, sign kind and destination of an outstanding load. A fault there surfaces exactly one cycle later as a wrong `load_data`, `load_rd` or `load_wb_en`, or as a `load_valid` pulse in the wrong cycle. Checking every response cycle against the request that caused it therefore pins down both paths.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  localparam int unsigned LS_XLEN  = 32;
  localparam int unsigned LS_BYTES = LS_XLEN / 8;
  localparam int unsigned LS_OFF_W = $clog2(LS_BYTES);
  localparam int unsigned LS_IMM_W = 12;
  localparam int unsigned LS_RIDX_W = 5;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } acc_size_e;

  typedef struct packed {
    acc_size_e               size;
    logic                    zero_ext;
    logic [LS_OFF_W-1:0]     lane;
    logic [LS_RIDX_W-1:0]    dest;
  } load_ctx_t;
endpackage

// File: rtl/ldst_addr_check.sv
module ldst_addr_check
  import ldst_pkg::*;
(
  input  logic                 req_valid,
  input  logic                 is_store,
  input  logic [2:0]           code,
  input  logic [LS_XLEN-1:0]   base,
  input  logic [LS_IMM_W-1:0]  offset,
  output logic [LS_XLEN-1:0]   addr,
  output acc_size_e            size,
  output logic                 zero_ext,
  output logic [LS_OFF_W-1:0]  lane,
  output logic                 misaligned,
  output logic                 illegal
);
  localparam int unsigned EXT_W = LS_XLEN - LS_IMM_W;

  logic legal;
  logic bad_align;

  assign addr     = base + {{EXT_W{offset[LS_IMM_W-1]}}, offset};
  assign lane     = addr[LS_OFF_W-1:0];
  assign size     = acc_size_e'(code[1:0]);
  assign zero_ext = code[2];

  always_comb begin
    unique case (code)
      3'b000, 3'b001, 3'b010: legal = 1'b1;
      3'b100, 3'b101:         legal = ~is_store;
      default:                legal = 1'b0;
    endcase
  end

  always_comb begin
    unique case (code[1:0])
      2'b01:   bad_align = addr[0];
      2'b10:   bad_align = |addr[LS_OFF_W-1:0];
      default: bad_align = 1'b0;
    endcase
  end

  assign illegal    = req_valid & ~legal;
  assign misaligned = req_valid & legal & bad_align;
endmodule

// File: rtl/ldst_store_lanes.sv
module ldst_store_lanes
  import ldst_pkg::*;
(
  input  acc_size_e            size,
  input  logic [LS_OFF_W-1:0]  lane,
  input  logic [LS_XLEN-1:0]   src,
  output logic [LS_BYTES-1:0]  strobe,
  output logic [LS_XLEN-1:0]   wdata
);
  localparam int unsigned HALVES = LS_BYTES / 2;

  logic [LS_BYTES-1:0] one_byte;
  logic [LS_BYTES-1:0] two_byte;

  assign one_byte = {{(LS_BYTES-1){1'b0}}, 1'b1};
  assign two_byte = {{(LS_BYTES-2){1'b0}}, 2'b11};

  always_comb begin
    unique case (size)
      SZ_BYTE: begin
        strobe = one_byte << lane;
        wdata  = {LS_BYTES{src[7:0]}};
      end
      SZ_HALF: begin
        strobe = two_byte << {lane[LS_OFF_W-1:1], 1'b0};
        wdata  = {HALVES{src[15:0]}};
      end
      default: begin
        strobe = {LS_BYTES{1'b1}};
        wdata  = src;
      end
    endcase
  end
endmodule

// File: rtl/ldst_load_extract.sv
module ldst_load_extract
  import ldst_pkg::*;
(
  input  acc_size_e            size,
  input  logic                 zero_ext,
  input  logic [LS_OFF_W-1:0]  lane,
  input  logic [LS_XLEN-1:0]   rword,
  output logic [LS_XLEN-1:0]   result
);
  logic [LS_XLEN-1:0] bytes_sel [LS_BYTES];
  logic [LS_XLEN-1:0] aligned;
  logic               sign_b;
  logic               sign_h;

  for (genvar g = 0; g < LS_BYTES; g++) begin : g_lane
    assign bytes_sel[g] = rword >> (8 * g);
  end

  assign aligned = bytes_sel[lane];
  assign sign_b  = ~zero_ext & aligned[7];
  assign sign_h  = ~zero_ext & aligned[15];

  always_comb begin
    unique case (size)
      SZ_BYTE: result = {{(LS_XLEN-8){sign_b}}, aligned[7:0]};
      SZ_HALF: result = {{(LS_XLEN-16){sign_h}}, aligned[15:0]};
      default: result = rword;
    endcase
  end
endmodule

// File: rtl/ldst_format_unit.sv
module ldst_format_unit
  import ldst_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_is_store,
  input  logic [2:0]            funct3,
  input  logic [LS_XLEN-1:0]    rs1,
  input  logic [LS_IMM_W-1:0]   imm12,
  input  logic [LS_XLEN-1:0]    rs2,
  input  logic [LS_RIDX_W-1:0]  rd,
  input  logic [LS_XLEN-1:0]    mem_rdata,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [LS_XLEN-1:0]    mem_addr,
  output logic [LS_BYTES-1:0]   byte_en,
  output logic [LS_XLEN-1:0]    mem_wdata,
  output logic [LS_XLEN-1:0]    eff_addr,
  output logic                  misaligned,
  output logic                  illegal,
  output logic                  load_valid,
  output logic [LS_XLEN-1:0]    load_data,
  output logic [LS_RIDX_W-1:0]  load_rd,
  output logic                  load_wb_en
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_n_int;
  acc_size_e              size;
  logic                   zero_ext;
  logic [LS_OFF_W-1:0]    lane;
  logic                   load_issue;
  logic                   resp_vld_d, resp_vld_q;
  load_ctx_t              ctx_d, ctx_q;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_int = rst_pipe[SYNC_STAGES-1];

  ldst_addr_check u_addr (
    .req_valid  (req_valid),
    .is_store   (req_is_store),
    .code       (funct3),
    .base       (rs1),
    .offset     (imm12),
    .addr       (eff_addr),
    .size       (size),
    .zero_ext   (zero_ext),
    .lane       (lane),
    .misaligned (misaligned),
    .illegal    (illegal)
  );

  ldst_store_lanes u_store (
    .size   (size),
    .lane   (lane),
    .src    (rs2),
    .strobe (byte_en),
    .wdata  (mem_wdata)
  );

  assign mem_addr   = {eff_addr[LS_XLEN-1:LS_OFF_W], {LS_OFF_W{1'b0}}};
  assign mem_req    = rst_n_int & req_valid & ~misaligned & ~illegal;
  assign mem_we     = mem_req & req_is_store;
  assign load_issue = mem_req & ~req_is_store;

  // next-state for the outstanding-load context
  always_comb begin
    resp_vld_d     = load_issue;
    ctx_d.size     = size;
    ctx_d.zero_ext = zero_ext;
    ctx_d.lane     = lane;
    ctx_d.dest     = rd;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) resp_vld_q <= 1'b0;
    else            resp_vld_q <= resp_vld_d;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)      ctx_q <= '0;
    else if (load_issue) ctx_q <= ctx_d;
  end

  ldst_load_extract u_load (
    .size     (ctx_q.size),
    .zero_ext (ctx_q.zero_ext),
    .lane     (ctx_q.lane),
    .rword    (mem_rdata),
    .result   (load_data)
  );

  assign load_valid = resp_vld_q;
  assign load_rd    = ctx_q.dest;
  assign load_wb_en = resp_vld_q & (ctx_q.dest != '0);
endmodule

// File: rtl/ldst_format_unit_chk.sv
module ldst_format_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_is_store,
  input logic [2:0] funct3,
  input logic       mem_req,
  input logic       mem_we,
  input logic [3:0] byte_en,
  input logic       misaligned,
  input logic       illegal,
  input logic       load_valid,
  input logic [4:0] load_rd,
  input logic       load_wb_en
);
  a_r2_no_access_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    misaligned |-> !mem_req);

  a_r8_illegal_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!misaligned && !mem_req));

  a_r3_word_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && funct3[1:0] == 2'b10) |-> byte_en == 4'hF);

  a_r3_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && funct3[1:0] == 2'b00) |-> $countones(byte_en) == 1);

  a_r10_resp_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> load_valid);

  a_r10_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && !mem_we) |=> !load_valid);

  a_r9_x0_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && load_rd == 5'd0) |-> !load_wb_en);

  a_r4_we_only_store: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_req && req_is_store));
endmodule

bind ldst_format_unit ldst_format_unit_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n_int),
  .req_valid    (req_valid),
  .req_is_store (req_is_store),
  .funct3       (funct3),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .byte_en      (byte_en),
  .misaligned   (misaligned),
  .illegal      (illegal),
  .load_valid   (load_valid),
  .load_rd      (load_rd),
  .load_wb_en   (load_wb_en)
);

// File: tb/ldst_format_unit_tb_top.sv
`timescale 1ns/1ps
module ldst_format_unit_tb_top;
  logic        clk;
  logic        rst_n;
  logic        req_valid, req_is_store;
  logic [2:0]  funct3;
  logic [31:0] rs1, rs2, mem_rdata;
  logic [11:0] imm12;
  logic [4:0]  rd;
  logic        mem_req, mem_we, misaligned, illegal;
  logic [31:0] mem_addr, mem_wdata, eff_addr, load_data;
  logic [3:0]  byte_en;
  logic        load_valid, load_wb_en;
  logic [4:0]  load_rd;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          finished = 0;

  ldst_format_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_store(req_is_store),
    .funct3(funct3), .rs1(rs1), .imm12(imm12), .rs2(rs2), .rd(rd),
    .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .byte_en(byte_en), .mem_wdata(mem_wdata), .eff_addr(eff_addr),
    .misaligned(misaligned), .illegal(illegal), .load_valid(load_valid),
    .load_data(load_data), .load_rd(load_rd), .load_wb_en(load_wb_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic exp_legal(input logic st, input logic [2:0] f);
    case (f)
      3'b000, 3'b001, 3'b010: return 1'b1;
      3'b100, 3'b101:         return !st;
      default:                return 1'b0;
    endcase
  endfunction

  function automatic logic exp_misal(input logic [2:0] f, input logic [31:0] a);
    if (f[1:0] == 2'b01) return a[0];
    if (f[1:0] == 2'b10) return a[1:0] != 2'b00;
    return 1'b0;
  endfunction

  function automatic logic [3:0] exp_be(input logic [2:0] f, input logic [1:0] o);
    if (f[1:0] == 2'b00) return 4'b0001 << o;
    if (f[1:0] == 2'b01) return o[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] exp_wd(input logic [2:0] f, input logic [31:0] v);
    if (f[1:0] == 2'b00) return {v[7:0], v[7:0], v[7:0], v[7:0]};
    if (f[1:0] == 2'b01) return {v[15:0], v[15:0]};
    return v;
  endfunction

  function automatic logic [31:0] exp_ld(input logic [2:0] f, input logic [1:0] o,
                                         input logic [31:0] w);
    logic [7:0]  b;
    logic [15:0] h;
    b = w[8*o +: 8];
    h = o[1] ? w[31:16] : w[15:0];
    case (f)
      3'b000:  return {{24{b[7]}}, b};
      3'b100:  return {24'h0, b};
      3'b001:  return {{16{h[15]}}, h};
      3'b101:  return {16'h0, h};
      default: return w;
    endcase
  endfunction

  task automatic do_req(input logic st, input logic [2:0] f, input logic [31:0] base,
                        input logic [11:0] off, input logic [31:0] src,
                        input logic [4:0] dst, input logic [31:0] rword);
    logic [31:0] a;
    logic        leg, mis, issue;
    a     = base + {{20{off[11]}}, off};
    leg   = exp_legal(st, f);
    mis   = leg && exp_misal(f, a);
    issue = leg && !mis;
    @(negedge clk);
    req_valid = 1'b1; req_is_store = st; funct3 = f;
    rs1 = base; imm12 = off; rs2 = src; rd = dst;
    #1;
    check("R1 eff_addr", eff_addr, a);
    check("R8 illegal", {31'h0, illegal}, {31'h0, !leg});
    check("R2 misaligned", {31'h0, misaligned}, {31'h0, mis});
    check("R2/R8 mem_req", {31'h0, mem_req}, {31'h0, issue});
    if (issue) begin
      check("R1 mem_addr", mem_addr, {a[31:2], 2'b00});
      check("R3 byte_en", {28'h0, byte_en}, {28'h0, exp_be(f, a[1:0])});
      check("R4 mem_we", {31'h0, mem_we}, {31'h0, st});
      if (st) check("R4 wdata", mem_wdata, exp_wd(f, src));
    end
    @(negedge clk);
    req_valid = 1'b0; mem_rdata = rword;
    #1;
    check("R10 load_valid", {31'h0, load_valid}, {31'h0, issue && !st});
    if (issue && !st) begin
      check(f[1:0] == 2'b00 ? "R5 byte load" : (f[1:0] == 2'b01 ? "R6 half load" : "R7 word load"),
            load_data, exp_ld(f, a[1:0], rword));
      check("R10 load_rd", {27'h0, load_rd}, {27'h0, dst});
      check("R9 wb_en", {31'h0, load_wb_en}, {31'h0, dst != 5'd0});
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] codes [6];
    codes[0] = 3'b000; codes[1] = 3'b001; codes[2] = 3'b010;
    codes[3] = 3'b100; codes[4] = 3'b101; codes[5] = 3'b011;
    void'($urandom(32'd1234));
    rst_n = 1'b0; req_valid = 1'b1; req_is_store = 1'b0; funct3 = 3'b010;
    rs1 = 32'h100; imm12 = 12'h0; rs2 = '0; rd = 5'd3; mem_rdata = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R11 mem_req in reset", {31'h0, mem_req}, 32'h0);
    check("R11 load_valid in reset", {31'h0, load_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R11 mem_req during sync", {31'h0, mem_req}, 32'h0);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 load_valid after sync", {31'h0, load_valid}, 32'h0);

    // directed corner cases
    do_req(0, 3'b010, 32'h1000, 12'h000, 0, 5'd1, 32'hFFFF_FFFF);
    for (int o = 0; o < 4; o++) begin
      do_req(0, 3'b000, 32'h2000 + o, 12'h0, 0, 5'd2, 32'h80C0_F090); // R5 signed
      do_req(0, 3'b100, 32'h2000 + o, 12'h0, 0, 5'd2, 32'h80C0_F090); // R5 unsigned
      do_req(1, 3'b000, 32'h3000, 12'(o), 32'hAB, 5'd0, 0);           // R3/R4 bytes
    end
    do_req(0, 3'b001, 32'h4002, 12'h0, 0, 5'd4, 32'h8001_7FFF);  // R6 upper signed
    do_req(0, 3'b101, 32'h4002, 12'h0, 0, 5'd4, 32'h8001_7FFF);  // R6 upper unsigned
    do_req(0, 3'b001, 32'h4000, 12'h0, 0, 5'd4, 32'h0001_8000);  // R6 lower signed
    do_req(0, 3'b001, 32'h4001, 12'h0, 0, 5'd4, 32'h0);          // R2 half odd
    do_req(0, 3'b010, 32'h4002, 12'h0, 0, 5'd4, 32'h0);          // R2 word at 2
    do_req(1, 3'b001, 32'h4003, 12'h0, 32'h1234, 5'd0, 0);       // R2 store half odd
    do_req(1, 3'b001, 32'h5000, 12'h002, 32'hCAFE_BEEF, 5'd0, 0);// R3 half lane 2
    do_req(0, 3'b010, 32'h0, 12'hFFC, 0, 5'd5, 32'h1357_9BDF);   // R1 wrap
    do_req(0, 3'b010, 32'h6000, 12'h0, 0, 5'd0, 32'h2468_ACE0);  // R9 x0 load
    do_req(0, 3'b010, 32'h6001, 12'h0, 0, 5'd0, 32'h0);          // R9 x0 misaligned
    do_req(0, 3'b011, 32'h7000, 12'h0, 0, 5'd6, 32'h0);          // R8 load 011
    do_req(0, 3'b111, 32'h7001, 12'h0, 0, 5'd6, 32'h0);          // R8 load 111
    do_req(1, 3'b100, 32'h7000, 12'h0, 32'h55, 5'd0, 0);         // R8 store 100

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic st;
      logic [2:0] f;
      st = 1'($urandom());
      f  = ($urandom_range(0, 9) == 0) ? 3'($urandom()) : codes[$urandom_range(0, 4)];
      do_req(st, f, $urandom(), 12'($urandom()), $urandom(),
             5'($urandom()), $urandom());
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule